// File: doc/BRIEF.md
# Floating-Point NaN Propagation Unit

This block sits beside the arithmetic core of a two-operand floating-point pipeline and decides, for each operation, whether the result has to be a NaN. It accepts a destination operand and a source operand in single, double or extended precision. It works out which NaN to return, if any, and whether a signaling NaN was seen. It also decides whether that signaling NaN must stop the write-back to the destination. When neither operand is a NaN and no invalid-operation request is raised, it reports "no NaN result" and the arithmetic path supplies the value.

A NaN in the destination always wins over the source; significands are never compared. When trapping on signaling NaNs is enabled, a signaling operand produces a trap and a blocked write instead of a quieted value. When some other invalid operation needs a NaN, the block returns the format's default NaN: sign clear and every other bit of the format set.

Operands travel on an 80-bit bus, right-aligned for the narrower formats. The block takes one operand pair per transfer over a valid/ready input and returns one registered result per transfer over a valid/ready output. An output that is not taken holds its value and stalls the input. The output stage is a single register, so `in_ready` is high whenever that register is empty or is being drained in the same cycle.

Top module: `fp_nan_prop`

## Requirements
- R1: An operand is a NaN when its exponent field is all ones and its fraction is nonzero. The exponent field is bits 30:23 for single, 62:52 for double and 78:64 for extended. The fraction is bits 22:0, 51:0 and 62:0 respectively, so the extended integer bit 63 is not part of it. The NaN is quiet when the top fraction bit (22, 51 or 62) is one and signaling otherwise. `fmt` is 00 for single, 01 for double, and 10 or 11 for extended.
- R2: When the destination is a NaN, quiet or signaling, the result is the destination NaN, whatever the source holds and whatever the two significands are.
- R3: When the destination is not a NaN and the source is, the result is the source NaN.
- R4: `snan_flag` is one when either operand is a signaling NaN.
- R5: When `trap_en` is one and either operand is a signaling NaN, `trap_taken` is one, `dst_wr` is zero, `res_nan` is zero and `res` is zero.
- R6: Without a trap, the returned NaN has its top fraction bit forced to one. A signaling NaN becomes quiet this way, and every other bit is kept.
- R7: When neither operand is a NaN and `dflt_req` is one, `res_nan` is one and `res` is the default NaN: 0x7FFFFFFF for single, 0x7FFFFFFFFFFFFFFF for double, and 0x7FFF in bits 79:64 with all ones in bits 63:0 for extended. A NaN operand takes precedence over `dflt_req`.
- R8: When neither operand is a NaN and `dflt_req` is zero, `res_nan` is zero, `res` is zero and `dst_wr` is one.
- R9: Operand bits above the selected format's width (bits 79:32 for single, 79:64 for double) are ignored, and those bits of `res` are zero.
- R10: A result appears on `out_valid` in the cycle after its input is accepted (`in_valid` and `in_ready` both high at a clock edge). `in_ready` is high when `out_valid` is low or `out_ready` is high. A result held with `out_ready` low stays unchanged.
- R11: After reset, `out_valid` is zero and `in_ready` is one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair is presented |
| in_ready | output | 1 | Block can take the operand pair this cycle |
| dst_op | input | 80 | Destination operand, right-aligned |
| src_op | input | 80 | Source operand, right-aligned |
| fmt | input | 2 | Format: 00 single, 01 double, 1x extended |
| dflt_req | input | 1 | Invalid operation needs a NaN even without NaN operands |
| trap_en | input | 1 | Trap on signaling NaN enabled |
| out_valid | output | 1 | Result is presented |
| out_ready | input | 1 | Consumer takes the result this cycle |
| res | output | 80 | NaN result, right-aligned, zero when no NaN |
| res_nan | output | 1 | `res` holds a NaN to be written |
| snan_flag | output | 1 | A signaling NaN was seen |
| trap_taken | output | 1 | Signaling-NaN trap taken |
| dst_wr | output | 1 | Destination may be written with this result |

## Verification
The hardest situation to reach is a trap or a quieted signaling NaN that arrives while the output register is stalled. The bench must show that the held result does not change and that the next pair is not taken early. Random traffic gets there by making each operand a quiet NaN, a signaling NaN, an infinity or random bits, with random garbage above the format width. The output is stalled on about one cycle in four. Directed cases cover the edges of the NaN test: an infinity, an extended value with only the integer bit set, and the smallest signaling fraction.

// File: rtl/fpnan_pkg.sv
package fpnan_pkg;

  localparam int OPW    = 80;
  localparam int SP_W   = 32;
  localparam int SP_EXP = 8;
  localparam int SP_FRC = 23;
  localparam int DP_W   = 64;
  localparam int DP_EXP = 11;
  localparam int DP_FRC = 52;
  localparam int XP_EXP = 15;
  localparam int XP_FRC = 63;
  localparam int XP_EB  = XP_FRC + 1;

  typedef enum logic [1:0] {
    FMT_S  = 2'b00,
    FMT_D  = 2'b01,
    FMT_X  = 2'b10,
    FMT_X2 = 2'b11
  } fmt_e;

  typedef struct packed {
    logic            nan;
    logic            snan;
    logic [OPW-1:0]  val;
  } opinfo_t;

  typedef struct packed {
    logic [OPW-1:0]  res;
    logic            nan;
    logic            snan;
    logic            trap;
  } result_t;

  function automatic logic [OPW-1:0] ones_below(input int w);
    logic [OPW-1:0] m;
    m = '0;
    for (int i = 0; i < OPW; i++) begin
      if (i < w) m[i] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [OPW-1:0] dflt_nan(input fmt_e f);
    case (f)
      FMT_S:   return ones_below(SP_W - 1);
      FMT_D:   return ones_below(DP_W - 1);
      default: return ones_below(OPW - 1);
    endcase
  endfunction

endpackage

// File: rtl/fpnan_classify.sv
module fpnan_classify
  import fpnan_pkg::*;
(
  input  logic [OPW-1:0] op,
  input  fmt_e           fmt,
  output opinfo_t        info
);

  always_comb begin
    info = '0;
    case (fmt)
      FMT_S: begin
        info.nan  = (&op[SP_FRC +: SP_EXP]) && (|op[SP_FRC-1:0]);
        info.snan = info.nan && !op[SP_FRC-1];
        info.val  = OPW'(op[SP_W-1:0]);
        info.val[SP_FRC-1] = 1'b1;
      end
      FMT_D: begin
        info.nan  = (&op[DP_FRC +: DP_EXP]) && (|op[DP_FRC-1:0]);
        info.snan = info.nan && !op[DP_FRC-1];
        info.val  = OPW'(op[DP_W-1:0]);
        info.val[DP_FRC-1] = 1'b1;
      end
      default: begin
        info.nan  = (&op[XP_EB +: XP_EXP]) && (|op[XP_FRC-1:0]);
        info.snan = info.nan && !op[XP_FRC-1];
        info.val  = op;
        info.val[XP_FRC-1] = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/fpnan_select.sv
module fpnan_select
  import fpnan_pkg::*;
(
  input  opinfo_t dst_i,
  input  opinfo_t src_i,
  input  fmt_e    fmt,
  input  logic    dflt_req,
  input  logic    trap_en,
  output result_t rsl
);

  always_comb begin
    rsl      = '0;
    rsl.snan = dst_i.snan || src_i.snan;
    rsl.trap = rsl.snan && trap_en;
    if (rsl.trap) begin
      rsl.nan = 1'b0;
    end else if (dst_i.nan) begin
      rsl.res = dst_i.val;
      rsl.nan = 1'b1;
    end else if (src_i.nan) begin
      rsl.res = src_i.val;
      rsl.nan = 1'b1;
    end else if (dflt_req) begin
      rsl.res = dflt_nan(fmt);
      rsl.nan = 1'b1;
    end
  end

endmodule

// File: rtl/fpnan_outreg.sv
module fpnan_outreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] d,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] q
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      q         <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (in_valid && in_ready) q <= d;
    end
  end

endmodule

// File: rtl/fp_nan_prop.sv
module fp_nan_prop
  import fpnan_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [OPW-1:0] dst_op,
  input  logic [OPW-1:0] src_op,
  input  logic [1:0]     fmt,
  input  logic           dflt_req,
  input  logic           trap_en,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [OPW-1:0] res,
  output logic           res_nan,
  output logic           snan_flag,
  output logic           trap_taken,
  output logic           dst_wr
);

  localparam int NOPS = 2;
  localparam int RW   = $bits(result_t);

  fmt_e           fmt_q;
  logic [OPW-1:0] ops   [NOPS];
  opinfo_t        infos [NOPS];
  result_t        nxt;
  result_t        cur;
  logic [RW-1:0]  cur_bits;

  assign fmt_q  = fmt_e'(fmt);
  assign ops[0] = dst_op;
  assign ops[1] = src_op;

  for (genvar g = 0; g < NOPS; g++) begin : g_cls
    fpnan_classify u_cls (
      .op   (ops[g]),
      .fmt  (fmt_q),
      .info (infos[g])
    );
  end

  fpnan_select u_sel (
    .dst_i    (infos[0]),
    .src_i    (infos[1]),
    .fmt      (fmt_q),
    .dflt_req (dflt_req),
    .trap_en  (trap_en),
    .rsl      (nxt)
  );

  fpnan_outreg #(.W(RW)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .d         (nxt),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .q         (cur_bits)
  );

  assign cur        = result_t'(cur_bits);
  assign res        = cur.res;
  assign res_nan    = cur.nan;
  assign snan_flag  = cur.snan;
  assign trap_taken = cur.trap;
  assign dst_wr     = out_valid && !cur.trap;

endmodule

// File: rtl/fp_nan_prop_chk.sv
module fp_nan_prop_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [79:0] res,
  input logic        res_nan,
  input logic        snan_flag,
  input logic        trap_taken,
  input logic        dst_wr
);

  // R11
  rst_clears_valid_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(res) && $stable(res_nan)
                                && $stable(snan_flag) && $stable(trap_taken));

  // R10
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R10
  empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R5
  trap_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && trap_taken |-> !dst_wr && !res_nan);

  // R4
  trap_needs_snan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && trap_taken |-> snan_flag);

  // R8
  write_only_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dst_wr |-> out_valid);

endmodule

bind fp_nan_prop fp_nan_prop_chk u_chk (.*);

// File: tb/tb_fp_nan_prop.sv
`timescale 1ns/1ps
module tb_fp_nan_prop;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [79:0] dst_op = '0;
  logic [79:0] src_op = '0;
  logic [1:0]  fmt = 2'b00;
  logic        dflt_req = 1'b0;
  logic        trap_en = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [79:0] res;
  logic        res_nan;
  logic        snan_flag;
  logic        trap_taken;
  logic        dst_wr;

  always #4 clk = ~clk;

  fp_nan_prop dut (.*);

  typedef struct {
    logic [79:0] res;
    bit          nan;
    bit          snan;
    bit          trap;
    string       tag;
  } exp_s;

  exp_s  q[$];
  int    checks = 0;
  int    errors = 0;
  bit    acc_prev = 0;
  bit    stall_mode = 0;
  string cur_tag = "RST";

  task automatic chk(bit ok, string req, string what, logic [79:0] act, logic [79:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic void geom(logic [1:0] f, output int fw, output int eb,
                               output int ew, output int wid);
    if (f == 2'b00) begin fw = 23; eb = 23; ew = 8;  wid = 32; end
    else if (f == 2'b01) begin fw = 52; eb = 52; ew = 11; wid = 64; end
    else begin fw = 63; eb = 64; ew = 15; wid = 80; end
  endfunction

  function automatic logic [79:0] trim(logic [79:0] x, logic [1:0] f);
    int fw, eb, ew, wid;
    geom(f, fw, eb, ew, wid);
    for (int i = wid; i < 80; i++) x[i] = 1'b0;
    return x;
  endfunction

  function automatic bit is_nan(logic [79:0] x, logic [1:0] f);
    int fw, eb, ew, wid;
    bit all1, nz;
    geom(f, fw, eb, ew, wid);
    all1 = 1; nz = 0;
    for (int i = eb; i < eb + ew; i++) if (!x[i]) all1 = 0;
    for (int i = 0; i < fw; i++) if (x[i]) nz = 1;
    return all1 && nz;
  endfunction

  function automatic bit is_snan(logic [79:0] x, logic [1:0] f);
    int fw, eb, ew, wid;
    geom(f, fw, eb, ew, wid);
    return is_nan(x, f) && !x[fw-1];
  endfunction

  function automatic logic [79:0] quiet(logic [79:0] x, logic [1:0] f);
    int fw, eb, ew, wid;
    geom(f, fw, eb, ew, wid);
    x = trim(x, f);
    x[fw-1] = 1'b1;
    return x;
  endfunction

  function automatic exp_s model(logic [79:0] d, logic [79:0] s, logic [1:0] f,
                                 bit en, bit dreq, string tag);
    exp_s e;
    int fw, eb, ew, wid;
    geom(f, fw, eb, ew, wid);
    e.tag  = tag;
    e.res  = '0;
    e.nan  = 0;
    e.snan = is_snan(d, f) || is_snan(s, f);
    e.trap = e.snan && en;
    if (e.trap) begin
      e.nan = 0;
    end else if (is_nan(d, f)) begin
      e.res = quiet(d, f); e.nan = 1;
    end else if (is_nan(s, f)) begin
      e.res = quiet(s, f); e.nan = 1;
    end else if (dreq) begin
      for (int i = 0; i < wid - 1; i++) e.res[i] = 1'b1;
      e.nan = 1;
    end
    return e;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (acc_prev) chk(out_valid === 1'b1, "R10", "latency out_valid", 80'(out_valid), 80'd1);
      chk(in_ready === (!out_valid || out_ready), "R10", "in_ready", 80'(in_ready),
          80'(!out_valid || out_ready));
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          chk(0, "R10", "unexpected result", 80'd1, 80'd0);
        end else begin
          exp_s e;
          e = q.pop_front();
          chk(res === e.res, e.tag, "res", res, e.res);
          chk(res_nan === e.nan, e.tag, "res_nan", 80'(res_nan), 80'(e.nan));
          chk(snan_flag === e.snan, "R4", "snan_flag", 80'(snan_flag), 80'(e.snan));
          chk(trap_taken === e.trap, "R5", "trap_taken", 80'(trap_taken), 80'(e.trap));
          chk(dst_wr === !e.trap, "R5", "dst_wr", 80'(dst_wr), 80'(!e.trap));
        end
      end
      acc_prev = in_valid && in_ready;
      if (acc_prev) q.push_back(model(dst_op, src_op, fmt, trap_en, dflt_req, cur_tag));
    end
  end

  always @(posedge clk) begin
    #1;
    if (stall_mode) out_ready <= (($urandom % 4) != 0);
    else out_ready <= 1'b1;
  end

  task automatic put(logic [79:0] d, logic [79:0] s, logic [1:0] f,
                     bit en, bit dreq, string tag);
    dst_op = d; src_op = s; fmt = f; trap_en = en; dflt_req = dreq;
    cur_tag = tag; in_valid = 1'b1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
  endtask

  function automatic logic [79:0] gen(logic [1:0] f);
    logic [79:0] x;
    int fw, eb, ew, wid, k;
    geom(f, fw, eb, ew, wid);
    x = {$urandom(), $urandom(), $urandom()};
    k = $urandom % 5;
    if (k == 1 || k == 2 || k == 3) for (int i = eb; i < eb + ew; i++) x[i] = 1'b1;
    if (k == 1) x[fw-1] = 1'b1;
    if (k == 2) begin x[fw-1] = 1'b0; x[0] = 1'b1; end
    if (k == 3) for (int i = 0; i < fw; i++) x[i] = 1'b0;
    if (k == 4) x[eb] = 1'b0;
    return x;
  endfunction

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R11
    chk(out_valid === 1'b0, "R11", "out_valid after reset", 80'(out_valid), 80'd0);
    chk(in_ready === 1'b1, "R11", "in_ready after reset", 80'(in_ready), 80'd1);
    @(posedge clk); #1;

    // R1: infinity, extended integer bit only, smallest signaling fraction
    put(80'h7F800000, 80'h3F800000, 2'b00, 0, 0, "R1");
    put({16'h7FFF, 64'h8000_0000_0000_0000}, 80'h0, 2'b10, 0, 0, "R1");
    put(80'h0, 80'h7F800001, 2'b00, 0, 0, "R1");
    put({16'hFFFF, 64'hC000_0000_0000_0000}, 80'h0, 2'b11, 0, 0, "R1");
    // R2: destination wins regardless of significand
    put(80'h7FC00001, 80'h7FFFFFFF, 2'b00, 0, 0, "R2");
    put(80'h7FF0_0000_0000_0001, 80'h7FFF_FFFF_FFFF_FFFF, 2'b01, 0, 0, "R2");
    // R3: source chosen when destination is a number
    put(80'h3FF0_0000_0000_0000, 80'hFFF8_0000_0000_1234, 2'b01, 0, 0, "R3");
    put(80'h7F800000, 80'h7F800010, 2'b00, 0, 0, "R3");
    // R4: signaling source, trap disabled
    put(80'h0, {16'h7FFF, 64'h0000_0000_0000_0005}, 2'b10, 0, 0, "R4");
    // R5: trap on signaling, no trap on quiet only
    put(80'h40000000, 80'h7F800001, 2'b00, 1, 0, "R5");
    put(80'h7FC00000, 80'h7FC00000, 2'b00, 1, 0, "R5");
    put(80'h7FF0_0000_0000_0001, 80'h0, 2'b01, 1, 1, "R5");
    // R6: quieting
    put(80'h7FF0_0000_0000_0001, 80'h0, 2'b01, 0, 0, "R6");
    put({16'h7FFF, 64'h8000_0000_0000_0001}, 80'h0, 2'b10, 0, 0, "R6");
    // R7: default NaN per format, and operand NaN overriding the request
    put(80'h3F800000, 80'h0, 2'b00, 0, 1, "R7");
    put(80'h0, 80'h0, 2'b01, 0, 1, "R7");
    put(80'h0, 80'h1, 2'b10, 0, 1, "R7");
    put(80'h0, 80'h7FC12345, 2'b00, 0, 1, "R7");
    // R8: no NaN, no request
    put(80'h3F800000, 80'h40000000, 2'b00, 0, 0, "R8");
    // R9: upper garbage ignored
    put({48'hFFFF_FFFF_FFFF, 32'h7FC00001}, 80'h0, 2'b00, 0, 0, "R9");
    put({16'hFFFF, 64'h3FF0_0000_0000_0000}, {48'hFFFF_FFFF_FFFF, 32'h0}, 2'b01, 0, 0, "R9");
    put({48'h7FFF_FFFF_FFFF, 32'h1}, 80'h0, 2'b00, 0, 0, "R9");

    stall_mode = 1;
    for (int n = 0; n < 3000; n++) begin
      logic [1:0] f;
      f = 2'($urandom % 4);
      put(gen(f), gen(f), f, ($urandom % 3) == 0, ($urandom % 4) == 0, "RND");
      if (($urandom % 8) == 0) begin
        in_valid = 1'b0;
        @(posedge clk); #1;
      end
    end
    in_valid = 1'b0;
    stall_mode = 0;
    while (q.size() != 0 || out_valid) @(posedge clk);
    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule